// File: doc/BRIEF.md
# Link Control Register with Role Strap

This block holds the 16-bit control word that software uses to steer a serial link's training logic. A static strap input picks the role of the port: root complex or endpoint. The strap decides which fields are writable and which are tied to fixed values. Software reaches the word through a simple register-bus port at one fixed address. The stored fields drive level outputs toward the training state machine: a power-management level, a shared-clock flag, a link-off level and an extended-synchronisation enable. The block also produces a one-cycle retrain request.

The training logic does not decode the extended-synchronisation bit itself. The block turns it into two ordered-set counts. One is the number of fast-training sets sent when leaving the light standby state. The other is the number of training sets sent before a deep-standby exit into recovery. With extended sync on, the counts are long so that an external monitor has time to lock onto the bit stream. With it off, the fast-training count comes from an input port and the training-set count is a short fixed value.

Top module: `link_ctl_reg`

## Requirements
- R1: After synchronous reset, the aspm_lvl, common_clk, link_off, ext_sync and retrain_req outputs are all 0. A read returns only bit 3, set to the value of role_rc. With fts_base held, the counts show their default values.
- R2: A read with rd_en high and rd_addr equal to REG_OFF (0x0E0) places the register image on rd_data one cycle later. In that image, bits 15:8 and bit 2 are always 0. In any cycle after a cycle with no matching read, rd_data is 0.
- R3: A write takes effect only when wr_addr equals REG_OFF and wr_be[0] is 1. A write with only wr_be[1] set, or one sent to any other address, changes nothing.
- R4: Bit 6 (shared reference clock) and bits 1:0 (power-management level) are read/write. They drive common_clk and aspm_lvl from the clock edge that captures the write.
- R5: Bit 5 is retrain. In root-complex role, a write with bit 5 set raises retrain_req for exactly one cycle, starting at the capturing edge. A write with bit 5 clear gives no pulse. Bit 5 always reads 0. In endpoint role, retrain_req never rises.
- R6: Bit 4 is link disable. In root-complex role, it reads back the last written value, and link_off follows it. In endpoint role, it reads 0 and link_off stays 0.
- R7: Bit 3 is read-only. It reads 1 in root-complex role (a 128-byte completion boundary) and 0 in endpoint role. Writes do not change it.
- R8: Bit 7 is extended sync and drives ext_sync. While it is set, fts_count is 4096 and ts1_count is 1024. Both counts change at the same edge as ext_sync.
- R9: While extended sync is clear, fts_count equals fts_base zero-extended, one cycle after fts_base is sampled, and ts1_count is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_rc | input | 1 | Role strap: 1 root complex, 0 endpoint |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address |
| wr_be | input | 2 | Byte enables for the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read address |
| rd_data | output | 16 | Registered read data |
| fts_base | input | 8 | Fast-training count used when extended sync is off |
| aspm_lvl | output | 2 | Permitted active-state power-management level |
| common_clk | output | 1 | Shared reference clock flag |
| link_off | output | 1 | Link disable level |
| retrain_req | output | 1 | One-cycle retrain request |
| ext_sync | output | 1 | Extended synchronisation enable |
| fts_count | output | 13 | Fast-training ordered sets to send on standby exit |
| ts1_count | output | 13 | Training sets to send before recovery |

## Verification
The bench targets the role-dependent fields. A design that ignores the strap would let an endpoint raise retrain_req or hold link_off, or it would report the wrong completion-boundary bit. The bench also checks that retrain reads 0 and pulses for a single cycle. A design that stored the bit would stretch the request or show it in readback. Upper-byte-only writes, writes to other addresses and ones written to preserved bits all check that nothing leaks into the image. Toggling extended sync and changing fts_base catch counts that lag ext_sync or that ignore the base input.

// File: rtl/link_ctl_pkg.sv
package link_ctl_pkg;
  localparam int REG_W   = 16;
  localparam int B_EXT   = 7;
  localparam int B_CCLK  = 6;
  localparam int B_RTRN  = 5;
  localparam int B_LOFF  = 4;
  localparam int B_RCB   = 3;
  localparam int ASPM_W  = 2;

  typedef struct packed {
    logic              ext;
    logic              cclk;
    logic              loff;
    logic [ASPM_W-1:0] aspm;
  } ctl_fields_t;
endpackage

// File: rtl/link_ctl_fields.sv
module link_ctl_fields
  import link_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              role_rc,
  input  logic              wr_hit,
  input  logic [7:0]        wr_lo,
  output ctl_fields_t       fld_q,
  output logic              ext_nxt,
  output logic              retrain_q
);
  ctl_fields_t fld_d;

  always_comb begin
    fld_d = fld_q;
    if (wr_hit) begin
      fld_d.ext  = wr_lo[B_EXT];
      fld_d.cclk = wr_lo[B_CCLK];
      fld_d.loff = wr_lo[B_LOFF];
      fld_d.aspm = wr_lo[ASPM_W-1:0];
    end
    if (!role_rc) fld_d.loff = 1'b0;
  end

  assign ext_nxt = fld_d.ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q     <= '0;
      retrain_q <= 1'b0;
    end else begin
      fld_q     <= fld_d;
      retrain_q <= wr_hit && role_rc && wr_lo[B_RTRN];
    end
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    retrain_q |=> !retrain_q);
  p_no_ep_retrain_r5: assert property (@(posedge clk) disable iff (rst)
    retrain_q |-> $past(role_rc));
  p_ep_loff_low_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(role_rc) |-> !fld_q.loff);
  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_hit) && $past(role_rc)) |-> $stable(fld_q));
endmodule

// File: rtl/link_ctl_counts.sv
module link_ctl_counts #(
  parameter int CNT_W    = 13,
  parameter int BASE_W   = 8,
  parameter int EXT_FTS  = 4096,
  parameter int EXT_TS1  = 1024,
  parameter int DFLT_TS1 = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_nxt,
  input  logic              ext_q,
  input  logic [BASE_W-1:0] fts_base,
  output logic [CNT_W-1:0]  fts_count,
  output logic [CNT_W-1:0]  ts1_count
);
  localparam logic [CNT_W-1:0] L_EXT_FTS  = CNT_W'(EXT_FTS);
  localparam logic [CNT_W-1:0] L_EXT_TS1  = CNT_W'(EXT_TS1);
  localparam logic [CNT_W-1:0] L_DFLT_TS1 = CNT_W'(DFLT_TS1);

  always_ff @(posedge clk) begin
    if (rst) begin
      fts_count <= CNT_W'(fts_base);
      ts1_count <= L_DFLT_TS1;
    end else if (ext_nxt) begin
      fts_count <= L_EXT_FTS;
      ts1_count <= L_EXT_TS1;
    end else begin
      fts_count <= CNT_W'(fts_base);
      ts1_count <= L_DFLT_TS1;
    end
  end

  p_ext_counts_r8: assert property (@(posedge clk) disable iff (rst)
    ext_q |-> (fts_count == L_EXT_FTS && ts1_count == L_EXT_TS1));
  p_dflt_ts1_r9: assert property (@(posedge clk) disable iff (rst)
    !ext_q |-> ts1_count == L_DFLT_TS1);
endmodule

// File: rtl/link_ctl_reg.sv
module link_ctl_reg
  import link_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] REG_OFF = 12'h0E0,
  parameter int          CNT_W   = 13,
  parameter int          BASE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               role_rc,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [1:0]         wr_be,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic [BASE_W-1:0]  fts_base,
  output logic [ASPM_W-1:0]  aspm_lvl,
  output logic               common_clk,
  output logic               link_off,
  output logic               retrain_req,
  output logic               ext_sync,
  output logic [CNT_W-1:0]   fts_count,
  output logic [CNT_W-1:0]   ts1_count
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFF);

  ctl_fields_t      fld_q;
  logic             ext_nxt;
  logic             wr_hit;
  logic             rd_hit;
  logic [REG_W-1:0] image;

  assign wr_hit = wr_en && (wr_addr == OFF) && wr_be[0];
  assign rd_hit = rd_en && (rd_addr == OFF);

  link_ctl_fields u_fields (
    .clk(clk), .rst(rst), .role_rc(role_rc), .wr_hit(wr_hit),
    .wr_lo(wr_data[7:0]), .fld_q(fld_q), .ext_nxt(ext_nxt),
    .retrain_q(retrain_req)
  );

  link_ctl_counts #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_counts (
    .clk(clk), .rst(rst), .ext_nxt(ext_nxt), .ext_q(fld_q.ext),
    .fts_base(fts_base), .fts_count(fts_count), .ts1_count(ts1_count)
  );

  always_comb begin
    image               = '0;
    image[B_EXT]        = fld_q.ext;
    image[B_CCLK]       = fld_q.cclk;
    image[B_LOFF]       = fld_q.loff;
    image[B_RCB]        = role_rc;
    image[ASPM_W-1:0]   = fld_q.aspm;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_hit ? image : '0;
  end

  assign aspm_lvl   = fld_q.aspm;
  assign common_clk = fld_q.cclk;
  assign link_off   = fld_q.loff;
  assign ext_sync   = fld_q.ext;

  p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_hit) |-> rd_data == '0);
  p_rtrn_reads_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_data[B_RTRN]);
  p_rcb_role_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit) |-> rd_data[B_RCB] == $past(role_rc));
endmodule

// File: tb/link_ctl_reg_tb_top.sv
module link_ctl_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFF = 12'h0E0;

  logic        clk = 0, rst = 1, role_rc = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [1:0]  wr_be = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [7:0]  fts_base = 8'd40;
  logic [1:0]  aspm_lvl;
  logic        common_clk, link_off, retrain_req, ext_sync;
  logic [12:0] fts_count, ts1_count;

  int checks = 0, errors = 0;
  logic m_ext, m_cc, m_ld;
  logic [1:0] m_aspm;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_ctl_reg dut_i (.*);

  function automatic logic [15:0] exp_image();
    return {8'h00, m_ext, m_cc, 1'b0, m_ld, role_rc, 1'b0, m_aspm};
  endfunction
  function automatic logic [12:0] exp_fts();
    return m_ext ? 13'd4096 : {5'd0, fts_base};
  endfunction
  function automatic logic [12:0] exp_ts1();
    return m_ext ? 13'd1024 : 13'd16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " aspm R4"}, aspm_lvl, m_aspm);
    chk({req, " cclk R4"}, common_clk, m_cc);
    chk({req, " loff R6"}, link_off, m_ld);
    chk({req, " ext R8"}, ext_sync, m_ext);
    chk({req, " fts R8/R9"}, fts_count, exp_fts());
    chk({req, " ts1 R8/R9"}, ts1_count, exp_ts1());
  endtask

  task automatic do_reset(input logic role);
    @(negedge clk); rst = 1; role_rc = role;
    @(negedge clk); @(negedge clk); rst = 0;
    m_ext = 0; m_cc = 0; m_ld = 0; m_aspm = 0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [1:0] be, input logic [15:0] d);
    logic hit, pulse;
    hit = (a == OFF) && be[0];
    pulse = hit && role_rc && d[5];
    @(negedge clk); wr_en = 1; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (hit) begin
      m_ext = d[7]; m_cc = d[6]; m_aspm = d[1:0]; m_ld = role_rc & d[4];
    end
    chk("R5 retrain pulse", retrain_req, pulse);
    chk_outs("R3 after write");
    @(negedge clk);
    chk("R5 retrain one cycle", retrain_req, 1'b0);
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
    chk(req, rd_data, (a == OFF) ? exp_image() : 16'h0);
    @(negedge clk);
    chk("R2 idle read zero", rd_data, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1 reset in both roles
    for (int r = 0; r < 2; r++) begin
      do_reset(r[0]);
      @(negedge clk);
      chk("R1 retrain reset", retrain_req, 1'b0);
      chk_outs("R1 reset");
      do_read(OFF, "R1/R7 reset image");
    end
    // directed root complex
    do_reset(1);
    do_write(OFF, 2'b01, 16'h00FF);
    do_read(OFF, "R2/R5/R6 image after all-ones low byte");
    do_write(OFF, 2'b10, 16'hFF00);
    do_read(OFF, "R3 upper-byte-only write ignored");
    do_write(12'h0E4, 2'b11, 16'h0000);
    do_read(OFF, "R3 other address ignored");
    do_write(OFF, 2'b11, 16'h0000);
    do_read(OFF, "R6 link disable cleared readback");
    do_write(OFF, 2'b01, 16'h0010);
    do_read(OFF, "R6 link disable set readback");
    do_write(OFF, 2'b01, 16'h0080);
    chk("R8 ext fts", fts_count, 13'd4096);
    chk("R8 ext ts1", ts1_count, 13'd1024);
    do_write(OFF, 2'b01, 16'h0000);
    @(negedge clk); fts_base = 8'd200;
    @(negedge clk);
    chk("R9 fts follows base", fts_count, 13'd200);
    chk("R9 ts1 default", ts1_count, 13'd16);
    do_read(12'h0E1, "R2 other address reads zero");
    // directed endpoint
    do_reset(0);
    do_write(OFF, 2'b01, 16'h00FF);
    do_read(OFF, "R5/R6/R7 endpoint hard-wired bits");
    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      do_reset(ph[0]);
      for (int i = 0; i < 150; i++) begin
        int op;
        op = $urandom % 5;
        case (op)
          0, 1: do_write(($urandom % 4 == 0) ? 12'($urandom) : OFF,
                         2'($urandom), 16'($urandom));
          2: do_read(OFF, "R2 random readback");
          3: begin
               @(negedge clk); fts_base = 8'($urandom);
               @(negedge clk); chk_outs("R9 random base");
             end
          default: do_read(12'($urandom), "R2 random address read");
        endcase
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule